// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This block holds four alarm fields and compares them with the running calendar time: minute, hour, weekday and day of month. The clock counter that owns the time supplies the current values in BCD, with the weekday as a one-hot code. It also gives a one-cycle `minute_tick` pulse on the cycle the time enters a new minute. Each alarm field has its own mask bit. A masked field takes no part in the comparison. The weekday alarm is a seven-bit set of days, so a single alarm can cover several weekdays.

When `minute_tick` coincides with a match, a sticky alarm flag is set. Software can clear the flag but cannot set it. While the flag and the interrupt enable are both 1, the registered active-low interrupt line `irq_n` is held low. A small register port gives write and read access to the four alarm fields and to the control register, which holds the flag and the enable.

Top module: `alarm_comparator`

## Requirements
- R1: Addresses 0 (minute), 1 (hour), 2 (weekday) and 3 (day of month) hold alarm fields. Bit 7 of each is its mask bit. The value bits are [6:0] for minute, [5:0] for hour, [6:0] for the weekday set (bit d = weekday d) and [5:0] for day. Bits outside these read back as 0.
- R2: Address 4 is the control register, with bit 0 as the interrupt enable and bit 1 as the alarm flag. All other bits read 0. `bus_rdata` is registered: it shows the register selected by `bus_addr` one clock after the address is applied, with the contents held before any write in that same cycle.
- R3: A field whose mask bit is 1 is ignored. A field whose mask bit is 0 matches only when its value equals the current time field. With all four fields masked, every minute tick is a match.
- R4: An unmasked weekday field matches when its set contains the bit that is high in `cur_wday`.
- R5: Matching is evaluated only on cycles with `minute_tick` high. A match sets the flag at that clock edge. A matching time with no tick sets nothing.
- R6: Once set, the flag stays set until a write to address 4 with bit 1 = 0 clears it. A write with bit 1 = 1 leaves the flag unchanged and cannot set it.
- R7: `irq_n` is 0 exactly when flag and enable are both 1, otherwise 1. It changes at the same clock edge as the flag or the enable.
- R8: When a match on a tick and a clearing write fall in the same cycle, the flag ends up set.
- R9: After synchronous reset, every register is 0, `bus_rdata` is 0 and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| minute_tick | input | 1 | One-cycle pulse on entry into a new minute |
| cur_min | input | 7 | Current minute, BCD |
| cur_hour | input | 6 | Current hour, BCD |
| cur_wday | input | 7 | Current weekday, one-hot |
| cur_mday | input | 6 | Current day of month, BCD |
| irq_n | output | 1 | Active-low alarm interrupt |

## Verification
The flag and `irq_n` both change at the clock edge that samples a matching tick or a control write. The bench therefore checks `irq_n` at the falling edge right after that rising edge. Read data comes one edge after the address, so a readback of the flag or of a field is sampled one full cycle after `bus_addr` is set. It shows the state from before any write in that same cycle. A behavioural model updates on each rising edge with this same latency and is compared with both outputs on every falling edge. Directed checks name each requirement at the cycle where its result is due.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam int MIN_W  = 7;
  localparam int HOUR_W = 6;
  localparam int WDAY_W = 7;
  localparam int MDAY_W = 6;
  localparam int NFIELD = 4;

  typedef enum logic [ADDR_W-1:0] {
    RA_MIN  = 3'd0,
    RA_HOUR = 3'd1,
    RA_WDAY = 3'd2,
    RA_MDAY = 3'd3,
    RA_CTRL = 3'd4
  } reg_addr_e;

  localparam int CTRL_IE_BIT   = 0;
  localparam int CTRL_FLAG_BIT = 1;

  function automatic int field_width(int idx);
    case (idx)
      0: return MIN_W;
      1: return HOUR_W;
      2: return WDAY_W;
      default: return MDAY_W;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] keep_mask(int idx);
    logic [DATA_W-1:0] m;
    m = '0;
    m[DATA_W-1] = 1'b1;
    for (int b = 0; b < DATA_W-1; b++)
      if (b < field_width(idx)) m[b] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/alm_regs.sv
module alm_regs
  import alm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        ctrl_val,
  output logic [DATA_W-1:0] field_q [NFIELD],
  output logic [DATA_W-1:0] rdata
);
  generate
    for (genvar i = 0; i < NFIELD; i++) begin : g_field
      localparam logic [DATA_W-1:0] KEEP = keep_mask(i);
      always_ff @(posedge clk) begin
        if (rst)
          field_q[i] <= '0;
        else if (we && addr == ADDR_W'(i))
          field_q[i] <= wdata & KEEP;
      end
    end
  endgenerate

  logic [DATA_W-1:0] rd_d;
  always_comb begin
    rd_d = '0;
    if (addr == RA_CTRL)
      rd_d[1:0] = ctrl_val;
    else if (int'(addr) < NFIELD)
      rd_d = field_q[addr[1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_d;
  end

  assert_hour_pad_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(addr) == RA_HOUR || $past(addr) == RA_MDAY) |-> (rdata[6] == 1'b0));
  assert_ctrl_pad_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(addr) == RA_CTRL) |-> (rdata[DATA_W-1:2] == '0));
endmodule

// File: rtl/alm_match.sv
module alm_match
  import alm_pkg::*;
(
  input  logic [DATA_W-1:0] field_q [NFIELD],
  input  logic [MIN_W-1:0]  cur_min,
  input  logic [HOUR_W-1:0] cur_hour,
  input  logic [WDAY_W-1:0] cur_wday,
  input  logic [MDAY_W-1:0] cur_mday,
  output logic              hit
);
  logic [NFIELD-1:0] field_ok;
  logic [NFIELD-1:0] field_eq;

  always_comb begin
    field_eq[0] = field_q[0][MIN_W-1:0]  == cur_min;
    field_eq[1] = field_q[1][HOUR_W-1:0] == cur_hour;
    field_eq[2] = |(field_q[2][WDAY_W-1:0] & cur_wday);
    field_eq[3] = field_q[3][MDAY_W-1:0] == cur_mday;
  end

  generate
    for (genvar i = 0; i < NFIELD; i++) begin : g_mask
      assign field_ok[i] = field_q[i][DATA_W-1] | field_eq[i];
    end
  endgenerate

  assign hit = &field_ok;
endmodule

// File: rtl/alm_flag.sv
module alm_flag
  import alm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tick,
  input  logic              hit,
  output logic              flag_q,
  output logic              ie_q,
  output logic              irq_n
);
  logic flag_d, ie_d;

  always_comb begin
    flag_d = flag_q;
    if (ctrl_wr && !wdata[CTRL_FLAG_BIT]) flag_d = 1'b0;
    if (tick && hit)                      flag_d = 1'b1;
    ie_d = ctrl_wr ? wdata[CTRL_IE_BIT] : ie_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
      irq_n  <= 1'b1;
    end else begin
      flag_q <= flag_d;
      ie_q   <= ie_d;
      irq_n  <= ~(flag_d & ie_d);
    end
  end

  assert_rise_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(tick && hit));
  assert_fall_on_clear_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_q) |-> $past(ctrl_wr && !wdata[CTRL_FLAG_BIT]));
  assert_irq_active_R7: assert property (@(posedge clk) disable iff (rst)
    (flag_q && ie_q) |-> !irq_n);
  assert_irq_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> (flag_q && ie_q));
  assert_collision_keeps_R8: assert property (@(posedge clk) disable iff (rst)
    (tick && hit && ctrl_wr) |=> flag_q);
endmodule

// File: rtl/alarm_comparator.sv
module alarm_comparator
  import alm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [2:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              minute_tick,
  input  logic [6:0]        cur_min,
  input  logic [5:0]        cur_hour,
  input  logic [6:0]        cur_wday,
  input  logic [5:0]        cur_mday,
  output logic              irq_n
);
  logic [DATA_W-1:0] field_q [NFIELD];
  logic hit, flag_q, ie_q, ctrl_wr;

  assign ctrl_wr = bus_we && (bus_addr == RA_CTRL);

  alm_regs u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .ctrl_val({flag_q, ie_q}), .field_q(field_q), .rdata(bus_rdata)
  );

  alm_match u_match (
    .field_q(field_q), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_wday(cur_wday), .cur_mday(cur_mday), .hit(hit)
  );

  alm_flag u_flag (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .wdata(bus_wdata),
    .tick(minute_tick), .hit(hit), .flag_q(flag_q), .ie_q(ie_q), .irq_n(irq_n)
  );

  assert_wday_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cur_wday));
endmodule

// File: tb/test_alarm_comparator.sv
module test_alarm_comparator;
  logic clk = 0, rst = 1;
  logic bus_we = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic minute_tick = 0;
  logic [6:0] cur_min = 0;
  logic [5:0] cur_hour = 0;
  logic [6:0] cur_wday = 7'h01;
  logic [5:0] cur_mday = 6'h01;
  logic irq_n;

  int checks = 0, errors = 0, cycles = 0;
  bit armed = 0;

  alarm_comparator i_alarm_comparator (.*);

  always #5 clk = ~clk;

  // behavioural reference
  logic [7:0] ma [4];
  bit m_flag, m_ie, m_irq_n = 1;
  logic [7:0] m_rd = 0;

  function automatic int dec(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic bit m_match();
    bit ok = 1, wd = 0;
    if (!ma[0][7] && dec({1'b0, ma[0][6:0]}) != dec({1'b0, cur_min})) ok = 0;
    if (!ma[1][7] && dec({2'b0, ma[1][5:0]}) != dec({2'b0, cur_hour})) ok = 0;
    if (!ma[2][7]) begin
      for (int d = 0; d < 7; d++) if (cur_wday[d] && ma[2][d]) wd = 1;
      if (!wd) ok = 0;
    end
    if (!ma[3][7] && dec({2'b0, ma[3][5:0]}) != dec({2'b0, cur_mday})) ok = 0;
    return ok;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (ma[k]) ma[k] = 0;
      m_flag = 0; m_ie = 0; m_irq_n = 1; m_rd = 0;
    end else begin
      bit hitnow;
      hitnow = minute_tick && m_match();
      if (bus_addr == 4) m_rd = {6'b0, m_flag, m_ie};
      else if (bus_addr < 4) m_rd = ma[bus_addr];
      else m_rd = 0;
      if (bus_we) begin
        case (bus_addr)
          0, 2: ma[bus_addr] = bus_wdata;
          1, 3: ma[bus_addr] = bus_wdata & 8'hBF;
          4: begin
            m_ie = bus_wdata[0];
            if (!bus_wdata[1]) m_flag = 0;
          end
          default: ;
        endcase
      end
      if (hitnow) m_flag = 1;
      m_irq_n = !(m_flag && m_ie);
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // continuous comparison on each falling edge
  always @(negedge clk) begin
    cycles++;
    if (armed) begin
      chk("R7 irq_n model", int'(irq_n), int'(m_irq_n));
      chk("R2 rdata model", int'(bus_rdata), int'(m_rd));
    end
  end

  task automatic wr(logic [2:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd_chk(logic [2:0] a, logic [7:0] exp, string tag);
    bus_addr = a;
    @(negedge clk);
    chk(tag, int'(bus_rdata), int'(exp));
  endtask

  task automatic set_time(logic [6:0] mi, logic [5:0] h, logic [6:0] w, logic [5:0] dm);
    cur_min = mi; cur_hour = h; cur_wday = w; cur_mday = dm;
  endtask

  task automatic tick();
    minute_tick = 1;
    @(negedge clk);
    minute_tick = 0;
  endtask

  task automatic clear_flag();
    wr(3'd4, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    armed = 1;
    @(negedge clk);
    chk("R9 irq_n after reset", int'(irq_n), 1);
    rd_chk(3'd0, 8'h00, "R9 minute field after reset");
    rd_chk(3'd4, 8'h00, "R9 control after reset");

    // R1 field storage and padding
    wr(3'd0, 8'hD9); rd_chk(3'd0, 8'hD9, "R1 minute readback");
    wr(3'd1, 8'hFF); rd_chk(3'd1, 8'hBF, "R1 hour pad bit");
    wr(3'd2, 8'hFF); rd_chk(3'd2, 8'hFF, "R1 weekday readback");
    wr(3'd3, 8'hFF); rd_chk(3'd3, 8'hBF, "R1 day pad bit");
    wr(3'd5, 8'hFF); rd_chk(3'd5, 8'h00, "R2 unmapped address reads 0");
    // R6 writing 1 to flag cannot set it; R2 enable stored
    wr(3'd4, 8'hFF); rd_chk(3'd4, 8'h01, "R6 write 1 no set");
    chk("R7 enable without flag", int'(irq_n), 1);

    // R3 exact match on minute+hour
    wr(3'd0, 8'h30); wr(3'd1, 8'h12); wr(3'd2, 8'h80); wr(3'd3, 8'h80);
    set_time(7'h30, 6'h12, 7'h04, 6'h09);
    bus_addr = 3'd4;
    repeat (3) @(negedge clk);
    chk("R5 no tick no alarm", int'(irq_n), 1);
    tick();
    chk("R3 match sets irq", int'(irq_n), 0);
    rd_chk(3'd4, 8'h03, "R3 flag set");
    repeat (4) @(negedge clk);
    chk("R6 flag sticky", int'(bus_rdata), 8'h03);
    clear_flag();
    chk("R6 clear releases irq", int'(irq_n), 1);
    rd_chk(3'd4, 8'h01, "R6 flag cleared");

    // R3 mismatching minute
    set_time(7'h31, 6'h12, 7'h04, 6'h09);
    tick();
    chk("R3 minute mismatch", int'(irq_n), 1);

    // R4 multi-day weekday set
    wr(3'd0, 8'h80); wr(3'd1, 8'h80); wr(3'd2, 8'h22);
    set_time(7'h05, 6'h07, 7'h20, 6'h09);
    tick();
    chk("R4 weekday in set", int'(irq_n), 0);
    clear_flag();
    set_time(7'h05, 6'h07, 7'h04, 6'h09);
    tick();
    chk("R4 weekday outside set", int'(irq_n), 1);
    set_time(7'h06, 6'h07, 7'h02, 6'h09);
    tick();
    chk("R4 second weekday in set", int'(irq_n), 0);
    clear_flag();

    // day of month
    wr(3'd2, 8'h80); wr(3'd3, 8'h15);
    set_time(7'h07, 6'h08, 7'h01, 6'h15);
    tick();
    chk("R3 day match", int'(irq_n), 0);
    clear_flag();
    set_time(7'h08, 6'h08, 7'h01, 6'h16);
    tick();
    chk("R3 day mismatch", int'(irq_n), 1);

    // R7 enable gating
    wr(3'd3, 8'h80);
    wr(3'd4, 8'h00);
    tick();
    chk("R7 masked irq stays high", int'(irq_n), 1);
    rd_chk(3'd4, 8'h02, "R7 flag set while disabled");
    wr(3'd4, 8'h03);
    chk("R7 enabling asserts irq", int'(irq_n), 0);
    clear_flag();

    // R8 collision of tick and clearing write
    bus_addr = 3'd4; bus_wdata = 8'h01; bus_we = 1; minute_tick = 1;
    @(negedge clk);
    bus_we = 0; minute_tick = 0;
    chk("R8 set wins over clear", int'(irq_n), 0);
    rd_chk(3'd4, 8'h03, "R8 flag readback");
    clear_flag();

    // R3 all fields masked fire on every tick
    for (int n = 0; n < 3; n++) begin
      set_time(7'(n), 6'h23, 7'h40, 6'h31);
      tick();
      chk("R3 all masked fires", int'(irq_n), 0);
      clear_flag();
    end

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule